// File: doc/BRIEF.md
# DMA Transfer Beat Scheduler

This block paces the data beats of a DMA engine whose internal buses are all 16 bits wide. When a transfer starts, the block takes the bus type at the source, the bus type at the destination, the element size and an element count. It turns each element into 16-bit beats and raises one read strobe per beat. A write strobe follows each read strobe, carrying the captured word. When the last write has gone out, the block gives a one-cycle completion pulse.

The spacing between beats comes from how the two ends share buses. A move between core memory and external memory uses two different buses, so it can issue a beat on every system-clock cycle. Other moves must issue at most one beat every second cycle:
- a move that uses the same bus at both ends (core to core, or external to external);
- any move with a peripheral at either end.

Address generation, descriptor handling and clock-domain crossing belong to neighbouring logic.

Top module: `dma_beat_sched`

## Requirements
- R1: Element sizes are coded 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. A 32-bit element takes two beats, and `beat_hi` is 0 on the first beat and 1 on the second. An 8-bit or 16-bit element takes one beat, with `beat_hi` at 0.
- R2: Bus types are coded 0 = core memory, 1 = peripheral and 2 = external memory. Between core and external memory, in either direction, read beats come on consecutive cycles.
- R3: When source and destination are both core memory, or both external memory, read beats are two cycles apart.
- R4: When either end is a peripheral, read beats are two cycles apart.
- R5: Every read strobe is followed, one cycle later, by a write strobe. The `wr_data` shown with that write strobe is the `rd_data` sampled in the read-strobe cycle.
- R6: For 8-bit elements, `wr_data` carries the low byte of the read word, and its upper byte is zero.
- R7: `done` is high for exactly one cycle, the cycle after the last write strobe. `busy` is high from the cycle after acceptance until `done` rises, and it is low while `done` is high.
- R8: A `start` that arrives while `busy` is high is ignored, even if its parameters differ. The running transfer keeps its beat count, its spacing and its `done` cycle.
- R9: A start with a count of zero issues no beats and never raises `busy`. It pulses `done` in the cycle after acceptance.
- R10: While reset is held, and right after it is released, `busy`, `done`, `rd_beat` and `wr_beat` are all low.
- R11: The first read strobe comes in the cycle right after the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; taken only when idle |
| src_bus | input | 2 | Source bus type (0 core, 1 peripheral, 2 external) |
| dst_bus | input | 2 | Destination bus type (0 core, 1 peripheral, 2 external) |
| elem_size | input | 2 | Element size (0 8-bit, 1 16-bit, 2 32-bit) |
| elem_count | input | CNT_W | Number of elements to move |
| rd_data | input | BUS_W | Word returned by the source for the current read beat |
| rd_beat | output | 1 | Read beat strobe |
| beat_hi | output | 1 | Qualifies `rd_beat`: upper half of a 32-bit element |
| wr_beat | output | 1 | Write beat strobe |
| wr_data | output | BUS_W | Word for the destination, valid with `wr_beat` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
All timing is counted from the edge that accepts `start`, which is cycle 0. Let I be the beat spacing and N the number of beats:
- read beat n is due in cycle 1 + n·I;
- its write comes one cycle later;
- `done` is due in cycle 3 + (N−1)·I, or in cycle 1 when the count is zero.

The bench drives inputs and samples outputs on the falling clock edge. At each falling edge it compares every output with these formulas, cycle by cycle, until two cycles past the expected `done`. This catches strobes that come early, late or extra, as well as a stretched completion pulse.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
   typedef enum logic [1:0] {
      BUS_CORE   = 2'd0,
      BUS_PERIPH = 2'd1,
      BUS_EXT    = 2'd2,
      BUS_RSVD   = 2'd3
   } bus_kind_e;

   typedef enum logic [1:0] {
      ELEM_8    = 2'd0,
      ELEM_16   = 2'd1,
      ELEM_32   = 2'd2,
      ELEM_RSVD = 2'd3
   } elem_size_e;
endpackage

// File: rtl/dma_rate_sel.sv
module dma_rate_sel
   import dma_sched_pkg::*;
#(
   parameter int FAST_GAP = 1,
   parameter int SLOW_GAP = 2,
   parameter int GAP_W    = 2
) (
   input  bus_kind_e        src_kind,
   input  bus_kind_e        dst_kind,
   output logic             slow,
   output logic [GAP_W-1:0] interval
);
   logic periph_end;
   logic shared_bus;

   // A reserved code is paced like a peripheral, which is the safe choice.
   assign periph_end = (src_kind == BUS_PERIPH) || (dst_kind == BUS_PERIPH) ||
                       (src_kind == BUS_RSVD)   || (dst_kind == BUS_RSVD);
   assign shared_bus = (src_kind == dst_kind);
   assign slow       = periph_end || shared_bus;

   generate
      if (FAST_GAP == SLOW_GAP) begin : g_uniform
         assign interval = GAP_W'(FAST_GAP);
      end else begin : g_split
         assign interval = slow ? GAP_W'(SLOW_GAP) : GAP_W'(FAST_GAP);
      end
   endgenerate
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
   parameter int GAP_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [GAP_W-1:0] interval,
   output logic             ready
);
   logic [GAP_W-1:0] wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= '0;
      end else if (load) begin
         wait_q <= '0;
      end else if (step) begin
         wait_q <= interval - GAP_W'(1);
      end else if (wait_q != '0) begin
         wait_q <= wait_q - GAP_W'(1);
      end
   end

   assign ready = (wait_q == '0);
endmodule

// File: rtl/dma_beat_track.sv
module dma_beat_track #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count,
   input  logic             wide_in,
   input  logic             step,
   output logic             left_zero,
   output logic             last_beat,
   output logic             hi,
   output logic             wide
);
   localparam int LEFT_W = CNT_W + 1;

   logic [LEFT_W-1:0] left_q;
   logic              hi_q;
   logic              wide_q;
   logic [LEFT_W-1:0] total;

   assign total = wide_in ? {count, 1'b0} : {1'b0, count};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         hi_q   <= 1'b0;
         wide_q <= 1'b0;
      end else if (load) begin
         left_q <= total;
         hi_q   <= 1'b0;
         wide_q <= wide_in;
      end else if (step) begin
         left_q <= left_q - LEFT_W'(1);
         if (wide_q) begin
            hi_q <= ~hi_q;
         end
      end
   end

   assign left_zero = (left_q == '0);
   assign last_beat = (left_q == LEFT_W'(1));
   assign hi        = hi_q;
   assign wide      = wide_q;
endmodule

// File: rtl/dma_wr_stage.sv
module dma_wr_stage #(
   parameter int BUS_W  = 16,
   parameter int LANE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_beat,
   input  logic             rd_last,
   input  logic             byte_mode,
   input  logic [BUS_W-1:0] rd_data,
   output logic             wr_beat,
   output logic [BUS_W-1:0] wr_data,
   output logic             wr_last
);
   logic [BUS_W-1:0] lane_word;

   assign lane_word = byte_mode ? {{(BUS_W-LANE_W){1'b0}}, rd_data[LANE_W-1:0]} : rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_beat <= 1'b0;
         wr_last <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_beat <= rd_beat;
         wr_last <= rd_beat & rd_last;
         if (rd_beat) begin
            wr_data <= lane_word;
         end
      end
   end
endmodule

// File: rtl/dma_beat_sched.sv
module dma_beat_sched
   import dma_sched_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int BUS_W    = 16,
   parameter int FAST_GAP = 1,
   parameter int SLOW_GAP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       src_bus,
   input  logic [1:0]       dst_bus,
   input  logic [1:0]       elem_size,
   input  logic [CNT_W-1:0] elem_count,
   input  logic [BUS_W-1:0] rd_data,
   output logic             rd_beat,
   output logic             beat_hi,
   output logic             wr_beat,
   output logic [BUS_W-1:0] wr_data,
   output logic             busy,
   output logic             done
);
   localparam int GAP_W  = $clog2(SLOW_GAP + 1);
   localparam int LANE_W = 8;

   generate
      if (BUS_W < 2 * LANE_W || (BUS_W % LANE_W) != 0) begin : g_bad_bus
         $error("BUS_W must be a multiple of 8 and at least 16");
      end
      if (FAST_GAP < 1 || SLOW_GAP < FAST_GAP) begin : g_bad_gap
         $error("need 1 <= FAST_GAP <= SLOW_GAP");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   logic             busy_q;
   logic             done_q;
   logic             slow_q;
   logic             byte_q;
   logic [GAP_W-1:0] ivl_q;

   logic             slow_sel;
   logic [GAP_W-1:0] ivl_sel;
   logic             accept;
   logic             zero_len;
   logic             load;
   logic             gap_ready;
   logic             left_zero;
   logic             last_beat;
   logic             hi_beat;
   logic             wide_q;
   logic             wr_last;

   assign accept   = start & ~busy_q;
   assign zero_len = (elem_count == '0);
   assign load     = accept & ~zero_len;

   dma_rate_sel #(
      .FAST_GAP (FAST_GAP),
      .SLOW_GAP (SLOW_GAP),
      .GAP_W    (GAP_W)
   ) i_rate (
      .src_kind (bus_kind_e'(src_bus)),
      .dst_kind (bus_kind_e'(dst_bus)),
      .slow     (slow_sel),
      .interval (ivl_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slow_q <= 1'b0;
         byte_q <= 1'b0;
         ivl_q  <= GAP_W'(FAST_GAP);
      end else if (load) begin
         slow_q <= slow_sel;
         byte_q <= (elem_size_e'(elem_size) == ELEM_8);
         ivl_q  <= ivl_sel;
      end
   end

   dma_gap_timer #(
      .GAP_W (GAP_W)
   ) i_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (rd_beat),
      .interval (ivl_q),
      .ready    (gap_ready)
   );

   dma_beat_track #(
      .CNT_W (CNT_W)
   ) i_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .count     (elem_count),
      .wide_in   (elem_size_e'(elem_size) == ELEM_32),
      .step      (rd_beat),
      .left_zero (left_zero),
      .last_beat (last_beat),
      .hi        (hi_beat),
      .wide      (wide_q)
   );

   assign rd_beat = busy_q & ~left_zero & gap_ready;
   assign beat_hi = rd_beat & hi_beat;

   dma_wr_stage #(
      .BUS_W  (BUS_W),
      .LANE_W (LANE_W)
   ) i_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_beat   (rd_beat),
      .rd_last   (last_beat),
      .byte_mode (byte_q),
      .rd_data   (rd_data),
      .wr_beat   (wr_beat),
      .wr_data   (wr_data),
      .wr_last   (wr_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= wr_last | (accept & zero_len);
         if (wr_last) begin
            busy_q <= 1'b0;
         end else if (load) begin
            busy_q <= 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/dma_beat_sched_chk.sv
module dma_beat_sched_chk #(
   parameter int SLOW_GAP = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic rd_beat,
   input logic wr_beat,
   input logic beat_hi,
   input logic slow_q,
   input logic wide_q,
   input logic wr_last
);
   p_hi_only_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_beat && beat_hi) |-> wide_q);

   p_slow_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_beat && slow_q && (SLOW_GAP > 1)) |=> !rd_beat);

   p_write_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_beat |=> wr_beat);

   p_write_has_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_beat |-> $past(rd_beat));

   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !rd_beat && !wr_beat));

   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wr_last) |=> busy);

   p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind dma_beat_sched dma_beat_sched_chk #(
   .SLOW_GAP (SLOW_GAP)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .rd_beat (rd_beat),
   .wr_beat (wr_beat),
   .beat_hi (beat_hi),
   .slow_q  (slow_q),
   .wide_q  (wide_q),
   .wr_last (wr_last)
);

// File: tb/test_dma_beat_sched.sv
module test_dma_beat_sched;
   localparam int CNT_W = 8;
   localparam int BUS_W = 16;
   localparam int NV    = 9;

   // {src, dst, size, count, interval}
   localparam logic [15:0] VEC [NV] = '{
      {2'd0, 2'd2, 2'd1, 8'd4, 2'd1},
      {2'd2, 2'd0, 2'd2, 8'd3, 2'd1},
      {2'd0, 2'd0, 2'd1, 8'd3, 2'd2},
      {2'd2, 2'd2, 2'd0, 8'd4, 2'd2},
      {2'd1, 2'd0, 2'd1, 8'd3, 2'd2},
      {2'd0, 2'd1, 2'd2, 8'd2, 2'd2},
      {2'd2, 2'd1, 2'd0, 8'd2, 2'd2},
      {2'd1, 2'd2, 2'd2, 8'd1, 2'd2},
      {2'd0, 2'd2, 2'd0, 8'd1, 2'd1}
   };

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start;
   logic [1:0]       src_bus;
   logic [1:0]       dst_bus;
   logic [1:0]       elem_size;
   logic [CNT_W-1:0] elem_count;
   logic [BUS_W-1:0] rd_data;
   logic             rd_beat;
   logic             beat_hi;
   logic             wr_beat;
   logic [BUS_W-1:0] wr_data;
   logic             busy;
   logic             done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dma_beat_sched #(
      .CNT_W (CNT_W),
      .BUS_W (BUS_W)
   ) i_dma_beat_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .src_bus    (src_bus),
      .dst_bus    (dst_bus),
      .elem_size  (elem_size),
      .elem_count (elem_count),
      .rd_data    (rd_data),
      .rd_beat    (rd_beat),
      .beat_hi    (beat_hi),
      .wr_beat    (wr_beat),
      .wr_data    (wr_data),
      .busy       (busy),
      .done       (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int k);
      return 16'hB700 + 16'(k * 37);
   endfunction

   task automatic run_case(input logic [1:0] s, input logic [1:0] d, input logic [1:0] z,
                           input int cnt, input int ivl, input string tag, input int inj_k);
      int n;
      int done_k;
      int rd_seen;
      bit ok_rd, ok_wr, ok_hi, ok_data, ok_done, ok_busy;
      int a_rd, e_rd_f, a_wr, e_wr_f, a_hi, e_hi_f, a_dat, e_dat_f, a_dn, e_dn_f, a_bz, e_bz_f;
      logic [15:0] prev_pat;
      n       = (z == 2'd2) ? 2 * cnt : cnt;
      done_k  = (n == 0) ? 1 : 3 + (n - 1) * ivl;
      rd_seen = 0;
      ok_rd = 1; ok_wr = 1; ok_hi = 1; ok_data = 1; ok_done = 1; ok_busy = 1;
      a_rd = 0; e_rd_f = 0; a_wr = 0; e_wr_f = 0; a_hi = 0; e_hi_f = 0;
      a_dat = 0; e_dat_f = 0; a_dn = 0; e_dn_f = 0; a_bz = 0; e_bz_f = 0;
      @(negedge clk);
      src_bus    = s;
      dst_bus    = d;
      elem_size  = z;
      elem_count = CNT_W'(cnt);
      rd_data    = pat(0);
      start      = 1'b1;
      prev_pat   = pat(0);
      for (int k = 1; k <= done_k + 2; k++) begin
         bit e_rd, e_wr, e_hi, e_done, e_busy;
         logic [15:0] e_dat;
         @(negedge clk);
         e_rd   = (n > 0) && ((k - 1) % ivl == 0) && ((k - 1) / ivl < n);
         e_hi   = e_rd && (z == 2'd2) && ((((k - 1) / ivl) % 2) == 1);
         e_wr   = (n > 0) && (k >= 2) && ((k - 2) % ivl == 0) && ((k - 2) / ivl < n);
         e_done = (k == done_k);
         e_busy = (n > 0) && (k < done_k);
         e_dat  = (z == 2'd0) ? {8'h00, prev_pat[7:0]} : prev_pat;
         if (rd_beat) rd_seen++;
         if (ok_rd && rd_beat !== e_rd) begin ok_rd = 0; a_rd = int'(rd_beat); e_rd_f = int'(e_rd); end
         if (ok_hi && beat_hi !== e_hi) begin ok_hi = 0; a_hi = int'(beat_hi); e_hi_f = int'(e_hi); end
         if (ok_wr && wr_beat !== e_wr) begin ok_wr = 0; a_wr = int'(wr_beat); e_wr_f = int'(e_wr); end
         if (ok_data && e_wr && wr_data !== e_dat) begin
            ok_data = 0; a_dat = int'(wr_data); e_dat_f = int'(e_dat);
         end
         if (ok_done && done !== e_done) begin ok_done = 0; a_dn = k; e_dn_f = done_k; end
         if (ok_busy && busy !== e_busy) begin ok_busy = 0; a_bz = int'(busy); e_bz_f = int'(e_busy); end
         prev_pat = pat(k);
         rd_data  = pat(k);
         if (k == inj_k) begin
            src_bus    = 2'd0;
            dst_bus    = 2'd2;
            elem_size  = 2'd1;
            elem_count = CNT_W'(10);
            start      = 1'b1;
         end else begin
            start = 1'b0;
         end
      end
      check(ok_rd,   {tag, " R11"}, "read strobe timing", a_rd, e_rd_f);
      check(rd_seen == n, {tag, " R1"}, "read beat count", rd_seen, n);
      check(ok_hi,   "R1", "beat_hi sequence", a_hi, e_hi_f);
      check(ok_wr,   "R5", "write strobe timing", a_wr, e_wr_f);
      check(ok_data, (z == 2'd0) ? "R6" : "R5", "write data", a_dat, e_dat_f);
      check(ok_done, {tag, " R7"}, "done cycle", a_dn, e_dn_f);
      check(ok_busy, "R7", "busy window", a_bz, e_bz_f);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      string tag;
      rst_n      = 1'b0;
      start      = 1'b0;
      src_bus    = 2'd0;
      dst_bus    = 2'd0;
      elem_size  = 2'd1;
      elem_count = '0;
      rd_data    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !done && !rd_beat && !wr_beat, "R10", "outputs in reset",
            int'({busy, done, rd_beat, wr_beat}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !rd_beat && !wr_beat, "R10", "outputs after reset",
            int'({busy, done, rd_beat, wr_beat}), 0);

      for (int v = 0; v < NV; v++) begin
         logic [1:0] s, d, z;
         int cnt, ivl;
         s   = VEC[v][15:14];
         d   = VEC[v][13:12];
         z   = VEC[v][11:10];
         cnt = int'(VEC[v][9:2]);
         ivl = int'(VEC[v][1:0]);
         if (ivl == 1)                       tag = "R2";
         else if (s == 2'd1 || d == 2'd1)    tag = "R4";
         else                                tag = "R3";
         run_case(s, d, z, cnt, ivl, tag, 0);
      end

      // R8: start with other parameters while a core-to-core move runs
      run_case(2'd0, 2'd0, 2'd1, 3, 2, "R8 R3", 3);
      @(negedge clk);
      check(!busy && !rd_beat, "R8", "no transfer from ignored start",
            int'({busy, rd_beat}), 0);

      // R9: zero count
      run_case(2'd2, 2'd0, 2'd1, 0, 1, "R9", 0);

      // back-to-back: a fresh transfer runs normally after the others
      run_case(2'd2, 2'd0, 2'd2, 2, 1, "R2", 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule